// File: doc/BRIEF.md
# Eight-bit ALU with compare flags

This block is the arithmetic and logic unit of a small 8-bit processor. Each cycle in which `valid_i` is high, it takes a 4-bit operation code and two register values, A and B. One clock later it presents a result together with a write strobe that tells the register file to store that result back into register A. Arithmetic wraps modulo 256. A zero divisor is refused with a one-cycle fault pulse, and in that case no write occurs.

The compare operation writes no register. Instead it loads a held flag word that records whether A is equal to, greater than or less than B. Exactly one of the three flag bits is set after a compare. The flag word keeps its value through every other operation, so a later conditional branch can test it.

Single-operand operations take no notice of B. These are increment, decrement and bitwise NOT.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high and after it is released, before any operation, `result_o`, `wr_en_o`, `fault_o` and `flags_o` are all zero.
- R2: Codes 0000 (add A+B), 0001 (subtract A-B), 0101 (increment A) and 0110 (decrement A) produce the result modulo 256, with `wr_en_o` high.
- R3: Code 0010 (multiply) returns the low 8 bits of the product A*B, with `wr_en_o` high.
- R4: Code 0011 returns the integer quotient A/B, and code 0100 returns the remainder A mod B. Both apply when B is non-zero, and both raise `wr_en_o`.
- R5: Codes 0011 and 0100 with B = 0 raise `fault_o` for exactly one cycle. In that cycle `wr_en_o` is low and `result_o` equals A unchanged.
- R6: Code 0111 (compare, unsigned) keeps `wr_en_o` low. It sets `flags_o` to 3'b001 when A = B, to 3'b010 when A > B, and to 3'b100 when A < B.
- R7: Any operation other than compare leaves `flags_o` unchanged, and so does a cycle without `valid_i`.
- R8: Codes 1000 (AND), 1010 (OR), 1011 (XOR) and 1001 (NOT A) produce the bitwise result, with `wr_en_o` high.
- R9: Code 1100 shifts A left and code 1101 shifts A right (logical), in both cases by the amount in B. An amount of 8 or more gives 0.
- R10: Increment, decrement and NOT give the same result whatever the value of B.
- R11: Results appear one clock after the `valid_i` cycle. In a cycle that follows one without `valid_i`, `wr_en_o` and `fault_o` are low.
- R12: The unused codes 1110 and 1111 raise neither `wr_en_o` nor `fault_o`, and they leave `flags_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation request this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Register A value |
| b_i | input | 8 | Register B value |
| result_o | output | 8 | Result for register A |
| wr_en_o | output | 1 | Write result back to register A |
| flags_o | output | 3 | Held compare flags {less, greater, equal} |
| fault_o | output | 1 | One-cycle divide/modulo-by-zero fault |

## Verification
The bench drives the wrap points, namely 0xFF+1, 0-1 and a multiply whose product exceeds 255. An adder of the wrong width or a truncation that kept the wrong bits would show there.

Divide and modulo by zero are checked for the fault pulse, for the suppressed write and for the fault clearing one cycle later. A design that wrote back the all-ones quotient, or held the fault high, would fail those checks.

Compares use operands that are equal, larger by one and smaller, including values with the top bit set. A signed comparator would flip the greater and less flags. Compares are then followed by non-compare and unused codes, to catch flags that are overwritten when they should be held.

Shift amounts of 7, 8 and 200 expose a shifter that uses only the low three bits of B. Unary operations are repeated with different B values to expose any dependence on the second operand.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int FLAG_W = 3;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0,
        OP_SUB = 4'h1,
        OP_MUL = 4'h2,
        OP_DIV = 4'h3,
        OP_MOD = 4'h4,
        OP_INC = 4'h5,
        OP_DEC = 4'h6,
        OP_CMP = 4'h7,
        OP_AND = 4'h8,
        OP_NOT = 4'h9,
        OP_OR  = 4'hA,
        OP_XOR = 4'hB,
        OP_SHL = 4'hC,
        OP_SHR = 4'hD,
        OP_RSV0 = 4'hE,
        OP_RSV1 = 4'hF
    } alu_op_e;

    // flag word bit positions: {less, greater, equal}
    localparam logic [FLAG_W-1:0] FLG_EQ = 3'b001;
    localparam logic [FLAG_W-1:0] FLG_GT = 3'b010;
    localparam logic [FLAG_W-1:0] FLG_LT = 3'b100;

    typedef enum logic [1:0] {
        GRP_ARITH,
        GRP_DIVIDE,
        GRP_BITWISE,
        GRP_NONE
    } alu_grp_e;

    typedef struct packed {
        logic wr;
        logic fault;
        logic flag_upd;
    } alu_ctl_t;

    function automatic alu_grp_e op_group(input alu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_INC, OP_DEC: op_group = GRP_ARITH;
            OP_DIV, OP_MOD:                         op_group = GRP_DIVIDE;
            OP_AND, OP_NOT, OP_OR, OP_XOR,
            OP_SHL, OP_SHR:                         op_group = GRP_BITWISE;
            default:                                op_group = GRP_NONE;
        endcase
    endfunction

    function automatic alu_ctl_t op_control(input alu_op_e op, input logic div_zero);
        alu_ctl_t c;
        c = '0;
        case (op_group(op))
            GRP_ARITH, GRP_BITWISE: c.wr = 1'b1;
            GRP_DIVIDE: begin
                c.wr    = !div_zero;
                c.fault = div_zero;
            end
            default: c.flag_upd = (op == OP_CMP);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] sum_w;
    logic [W-1:0] diff_w;
    logic [W-1:0] prod_w;
    logic [W-1:0] inc_w;
    logic [W-1:0] dec_w;

    assign sum_w  = a_i + b_i;
    assign diff_w = a_i - b_i;
    assign prod_w = a_i * b_i;
    assign inc_w  = a_i + ONE;
    assign dec_w  = a_i - ONE;

    always_comb begin
        case (op_i)
            OP_ADD:  y_o = sum_w;
            OP_SUB:  y_o = diff_w;
            OP_MUL:  y_o = prod_w;
            OP_INC:  y_o = inc_w;
            OP_DEC:  y_o = dec_w;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_divmod.sv
module alu8_divmod #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         zero_o
);
    logic [W-1:0] rem_w;
    logic [W-1:0] quo_w;
    logic [W:0]   shifted_w;
    logic [W:0]   trial_w;

    // restoring division, one quotient bit per step, MSB first
    always_comb begin
        rem_w     = '0;
        quo_w     = '0;
        shifted_w = '0;
        trial_w   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            shifted_w = {rem_w, a_i[i]};
            trial_w   = shifted_w - {1'b0, b_i};
            if (!trial_w[W]) begin
                rem_w    = trial_w[W-1:0];
                quo_w[i] = 1'b1;
            end else begin
                rem_w = shifted_w[W-1:0];
            end
        end
    end

    assign quo_o  = quo_w;
    assign rem_o  = rem_w;
    assign zero_o = (b_i == '0);
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam int SHW = $clog2(W);

    logic         over_w;
    logic [W-1:0] shl_w;
    logic [W-1:0] shr_w;

    // any amount of W or more clears the result
    generate
        if (W > (1 << SHW) - 1 && SHW < W) begin : g_wide_amt
            assign over_w = (b_i >= W[W-1:0]);
        end else begin : g_narrow_amt
            assign over_w = 1'b0;
        end
    endgenerate

    assign shl_w = over_w ? '0 : (a_i << b_i[SHW-1:0]);
    assign shr_w = over_w ? '0 : (a_i >> b_i[SHW-1:0]);

    always_comb begin
        case (op_i)
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_NOT:  y_o = ~a_i;
            OP_SHL:  y_o = shl_w;
            OP_SHR:  y_o = shr_w;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_compare.sv
module alu8_compare
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    output logic [FLAG_W-1:0] flags_o
);
    always_comb begin
        if (a_i == b_i)     flags_o = FLG_EQ;
        else if (a_i > b_i) flags_o = FLG_GT;
        else                flags_o = FLG_LT;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    output logic [W-1:0]      result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              fault_o
);
    alu_op_e           op_w;
    alu_ctl_t          ctl_w;
    logic [W-1:0]      arith_y;
    logic [W-1:0]      bit_y;
    logic [W-1:0]      quo_y;
    logic [W-1:0]      rem_y;
    logic              div_zero;
    logic [FLAG_W-1:0] cmp_flags;
    logic [W-1:0]      next_res;

    logic [W-1:0]      result_q;
    logic              wr_q;
    logic              fault_q;
    logic [FLAG_W-1:0] flags_q;

    assign op_w = alu_op_e'(op_i);

    alu8_arith #(.W(W)) u_arith (
        .op_i (op_w),
        .a_i  (a_i),
        .b_i  (b_i),
        .y_o  (arith_y)
    );

    alu8_divmod #(.W(W)) u_divmod (
        .a_i    (a_i),
        .b_i    (b_i),
        .quo_o  (quo_y),
        .rem_o  (rem_y),
        .zero_o (div_zero)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op_i (op_w),
        .a_i  (a_i),
        .b_i  (b_i),
        .y_o  (bit_y)
    );

    alu8_compare #(.W(W)) u_cmp (
        .a_i     (a_i),
        .b_i     (b_i),
        .flags_o (cmp_flags)
    );

    assign ctl_w = op_control(op_w, div_zero);

    always_comb begin
        case (op_group(op_w))
            GRP_ARITH:   next_res = arith_y;
            GRP_BITWISE: next_res = bit_y;
            GRP_DIVIDE: begin
                if (div_zero)           next_res = a_i;
                else if (op_w == OP_MOD) next_res = rem_y;
                else                    next_res = quo_y;
            end
            default:     next_res = a_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            wr_q     <= 1'b0;
            fault_q  <= 1'b0;
            flags_q  <= '0;
        end else begin
            wr_q    <= 1'b0;
            fault_q <= 1'b0;
            if (valid_i) begin
                result_q <= next_res;
                wr_q     <= ctl_w.wr;
                fault_q  <= ctl_w.fault;
                if (ctl_w.flag_upd) flags_q <= cmp_flags;
            end
        end
    end

    assign result_o = result_q;
    assign wr_en_o  = wr_q;
    assign fault_o  = fault_q;
    assign flags_o  = flags_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         valid_i,
    input logic [3:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] result_o,
    input logic         wr_en_o,
    input logic [2:0]   flags_o,
    input logic         fault_o
);
    p_flags_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags_o));

    p_fault_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !wr_en_o);

    p_fault_cause_r5: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> ($past(valid_i) && $past(b_i) == '0 &&
                     ($past(op_i) == 4'h3 || $past(op_i) == 4'h4)));

    p_fault_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (fault_o && !valid_i) |=> !fault_o);

    p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && $past(op_i) == 4'h7) |-> !wr_en_o);

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(valid_i) && $past(op_i) == 4'h7)) |-> $stable(flags_o));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_i) |-> (!wr_en_o && !fault_o));

    p_add_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i) && $past(op_i) == 4'h0)
            |-> (wr_en_o && result_o == W'($past(a_i) + $past(b_i))));

    p_reserved_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_i) && $past(op_i) >= 4'hE) |-> (!wr_en_o && !fault_o));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_alu8_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o),
    .fault_o  (fault_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid_i = 1'b0;
    logic [3:0] op_i = 4'h0;
    logic [7:0] a_i = 8'h00;
    logic [7:0] b_i = 8'h00;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic [2:0] flags_o;
    logic       fault_o;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_flags = 3'b000;

    always #2 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .flags_o(flags_o), .fault_o(fault_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one request, then sample one negedge later (one register on the path)
    task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [3:0] op,
                                input logic [7:0] a, input logic [7:0] b, input int exp);
        issue(op, a, b);
        chk(req, "result", int'(result_o), exp);
        chk(req, "wr_en", int'(wr_en_o), 1);
        chk(req, "fault", int'(fault_o), 0);
        chk(req, "flags held", int'(flags_o), int'(exp_flags));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "result in reset", int'(result_o), 0);
        chk("R1", "wr_en in reset", int'(wr_en_o), 0);
        chk("R1", "flags in reset", int'(flags_o), 0);
        chk("R1", "fault in reset", int'(fault_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "wr_en after release", int'(wr_en_o), 0);
        chk("R1", "flags after release", int'(flags_o), 0);
    endtask

    task automatic t_arith();
        expect_write("R2", 4'h0, 8'h12, 8'h34, 'h46);
        expect_write("R2", 4'h0, 8'hFF, 8'h01, 'h00);
        expect_write("R2", 4'h1, 8'h00, 8'h01, 'hFF);
        expect_write("R2", 4'h1, 8'h50, 8'h20, 'h30);
        expect_write("R2", 4'h5, 8'hFF, 8'h00, 'h00);
        expect_write("R2", 4'h6, 8'h00, 8'h00, 'hFF);
        expect_write("R3", 4'h2, 8'h10, 8'h11, 'h10);
        expect_write("R3", 4'h2, 8'h0C, 8'h0B, 'h84);
        expect_write("R3", 4'h2, 8'hFF, 8'hFF, 'h01);
    endtask

    task automatic t_divmod();
        expect_write("R4", 4'h3, 8'd200, 8'd7, 28);
        expect_write("R4", 4'h4, 8'd200, 8'd7, 4);
        expect_write("R4", 4'h3, 8'd5, 8'd9, 0);
        expect_write("R4", 4'h4, 8'd5, 8'd9, 5);
        expect_write("R4", 4'h3, 8'hFF, 8'h01, 'hFF);
        expect_write("R4", 4'h4, 8'hFF, 8'hFF, 0);
    endtask

    task automatic t_divzero();
        for (int k = 0; k < 2; k++) begin
            issue(k == 0 ? 4'h3 : 4'h4, 8'h5A, 8'h00);
            chk("R5", "fault on zero divisor", int'(fault_o), 1);
            chk("R5", "no write on fault", int'(wr_en_o), 0);
            chk("R5", "A unchanged", int'(result_o), 'h5A);
            @(negedge clk);
            chk("R5", "fault lasts one cycle", int'(fault_o), 0);
            chk("R11", "idle cycle no write", int'(wr_en_o), 0);
        end
    endtask

    task automatic t_compare();
        issue(4'h7, 8'h80, 8'h80); exp_flags = 3'b001;
        chk("R6", "equal", int'(flags_o), 1);
        chk("R6", "cmp no write", int'(wr_en_o), 0);
        issue(4'h7, 8'h81, 8'h80); exp_flags = 3'b010;
        chk("R6", "greater", int'(flags_o), 2);
        issue(4'h7, 8'h01, 8'hF0); exp_flags = 3'b100;
        chk("R6", "less unsigned", int'(flags_o), 4);
        issue(4'h7, 8'hF0, 8'h01); exp_flags = 3'b010;
        chk("R6", "greater unsigned", int'(flags_o), 2);
    endtask

    task automatic t_flag_hold();
        expect_write("R7", 4'h0, 8'h01, 8'h01, 2);
        issue(4'h3, 8'h01, 8'h00);
        chk("R7", "flags held on fault", int'(flags_o), int'(exp_flags));
        repeat (3) @(negedge clk);
        chk("R7", "flags held idle", int'(flags_o), int'(exp_flags));
    endtask

    task automatic t_logic();
        expect_write("R8", 4'h8, 8'hCC, 8'hAA, 'h88);
        expect_write("R8", 4'hA, 8'hCC, 8'hAA, 'hEE);
        expect_write("R8", 4'hB, 8'hCC, 8'hAA, 'h66);
        expect_write("R8", 4'h9, 8'hCC, 8'h00, 'h33);
    endtask

    task automatic t_shift();
        expect_write("R9", 4'hC, 8'h81, 8'd1, 'h02);
        expect_write("R9", 4'hC, 8'h01, 8'd7, 'h80);
        expect_write("R9", 4'hC, 8'hFF, 8'd8, 'h00);
        expect_write("R9", 4'hC, 8'hFF, 8'd200, 'h00);
        expect_write("R9", 4'hD, 8'h80, 8'd7, 'h01);
        expect_write("R9", 4'hD, 8'hFF, 8'd9, 'h00);
        expect_write("R9", 4'hD, 8'hF0, 8'd0, 'hF0);
    endtask

    task automatic t_unary();
        expect_write("R10", 4'h5, 8'h41, 8'h55, 'h42);
        expect_write("R10", 4'h5, 8'h41, 8'hFF, 'h42);
        expect_write("R10", 4'h6, 8'h41, 8'hAA, 'h40);
        expect_write("R10", 4'h9, 8'h0F, 8'hFF, 'hF0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        op_i = 4'h0; a_i = 8'h03; b_i = 8'h04; valid_i = 1'b1;
        @(posedge clk); #1;
        valid_i = 1'b0;
        chk("R11", "result after one edge", int'(result_o), 7);
        chk("R11", "write after one edge", int'(wr_en_o), 1);
        @(negedge clk);
        @(negedge clk);
        chk("R11", "write drops when idle", int'(wr_en_o), 0);
    endtask

    task automatic t_reserved();
        for (int c = 14; c < 16; c++) begin
            issue(4'(c), 8'h10, 8'h20);
            chk("R12", "no write", int'(wr_en_o), 0);
            chk("R12", "no fault", int'(fault_o), 0);
            chk("R12", "flags held", int'(flags_o), int'(exp_flags));
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_arith();
        t_divmod();
        t_divzero();
        t_compare();
        t_flag_hold();
        t_logic();
        t_shift();
        t_unary();
        t_latency();
        t_reserved();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule